// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps a free-running precision time clock: a 48-bit seconds count and a 30-bit nanoseconds count. On every clock cycle it advances the nanoseconds by a programmable step. The step has an 8-bit whole-nanosecond part and a 24-bit fractional part. The fraction is summed in an accumulator, and each overflow of that accumulator adds one extra nanosecond to the step. When the nanoseconds count reaches one billion, it folds back, the seconds count advances, and a one-cycle pulse marks the new second.

Software reaches the block through a flat word-wide write port and a combinational read port.

- **Seconds:** the upper half of the seconds value is staged in a holding register. It reaches the running counter only when the lower half is written, so the 48-bit value changes in a single cycle.
- **Fractional step:** writes to the fractional step are also staged. They take effect together with the next write of the whole-nanosecond step.
- **Offset:** a signed one-shot offset register shifts the running time by less than one second. It borrows from or carries into the seconds as needed.

Top module: `ptp_tod_counter`

## Requirements
- R1: After a synchronous active-low reset, seconds, nanoseconds, both step parts, the staged values and the pulse are zero. While both step parts are zero, the time holds still.
- R2: On each clock edge without a time-register write, nanoseconds advance by the whole step. They advance by one more when adding the 24-bit fraction to the 24-bit accumulator overflows.
- R3: The fraction is written at offset 4. Data bits [15:0] form fraction bits [23:8], and data bits [31:24] form fraction bits [7:0]. A read of offset 4 returns the active fraction in the same layout.
- R4: A write to offset 4 only stages the fraction. The staged fraction becomes active on the next write to offset 3, which sets the whole step from data bits [7:0].
- R5: When a step brings nanoseconds to 1,000,000,000 or beyond, nanoseconds lose 10^9, seconds gain one, and the pulse output is high for exactly that one cycle.
- R6: Offset 0 stages seconds [47:32] from data bits [15:0] and leaves the running seconds unchanged. A write to offset 1 loads {staged high, data} into the seconds in one cycle. Reads of offsets 0, 1 and 2 return the running seconds high, seconds low and nanoseconds.
- R7: A write to offset 2 sets nanoseconds to data bits [29:0]. That cycle's step is dropped, so the write causes no carry into the seconds.
- R8: A write to offset 5 applies once, in place of that cycle's step, an offset whose magnitude is in data bits [29:0] and whose sign is in bit 31 (1 subtracts).
  - A subtraction below zero borrows a second and adds 10^9 to nanoseconds.
  - An addition reaching 10^9 carries a second and raises the pulse.
  - A read of offset 5 returns zero.
- R9: An offset with magnitude of 10^9 or more is ignored, and that cycle steps normally.
- R10: When a bus write to offset 1 falls in the cycle where the count would carry a second, the written seconds win and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register offset for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Register offset for the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| tod_sec | output | 48 | Running seconds |
| tod_ns | output | 30 | Running nanoseconds |
| pps_pulse | output | 1 | One-cycle pulse at each seconds carry |

## Verification
Two events can land on the same edge: the counter's own seconds carry, and a software write to the seconds-low register. The bench starts the clock a few nanoseconds below the second boundary with a known step. It then times a staged seconds load so that the load hits exactly the wrapping edge.

The bench judges the result by three values:
- the seconds must equal the written value, not the written value plus one;
- the nanoseconds must still wrap;
- the pulse must stay low.

A second collision is also provoked: a nanosecond write lands on the cycle after the step is enabled near the boundary. The bench checks that no pulse or seconds carry leaks through.

// File: rtl/ptp_tod_pkg.sv
// Package: shared widths, register offsets and constants for the time-of-day counter.
package ptp_tod_pkg;
    parameter int SEC_W     = 48;
    parameter int NS_W      = 30;
    parameter int INC_NS_W  = 8;
    parameter int FRAC_W    = 24;
    parameter int DATA_W    = 32;
    parameter int ADDR_W    = 3;
    localparam int SEC_LO_W = DATA_W;
    localparam int SEC_HI_W = SEC_W - SEC_LO_W;
    localparam int STEP_W   = INC_NS_W + 1;
    localparam int SIGN_BIT = DATA_W - 1;
    localparam longint unsigned NS_PER_SEC = 64'd1_000_000_000;

    typedef enum logic [ADDR_W-1:0] {
        REG_SEC_HI  = 3'd0,
        REG_SEC_LO  = 3'd1,
        REG_NSEC    = 3'd2,
        REG_STEP_NS = 3'd3,
        REG_STEP_FR = 3'd4,
        REG_OFFSET  = 3'd5
    } tod_reg_e;
endpackage

// File: rtl/ptp_step_regs.sv
// Step registers: holds the active whole/fractional step and a staged fraction.
// Assumes: fraction write only stages; whole-step write commits both parts.
module ptp_step_regs
    import ptp_tod_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frac_wr,
    input  logic                whole_wr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [INC_NS_W-1:0] step_whole,
    output logic [FRAC_W-1:0]   step_frac,
    output logic [DATA_W-1:0]   frac_packed
);
    localparam int HI_PART = FRAC_W - 8;

    logic [FRAC_W-1:0] frac_stage;
    logic [FRAC_W-1:0] frac_unpacked;

    // Purpose: reassemble the fraction from its split register layout.
    always_comb begin
        frac_unpacked = {wr_data[HI_PART-1:0], wr_data[DATA_W-1:DATA_W-8]};
    end

    // Purpose: stage the fraction, commit both step parts on a whole-step write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frac_stage <= '0;
            step_whole <= '0;
            step_frac  <= '0;
        end else begin
            if (frac_wr) begin
                frac_stage <= frac_unpacked;
            end
            if (whole_wr) begin
                step_whole <= wr_data[INC_NS_W-1:0];
                step_frac  <= frac_stage;
            end
        end
    end

    // Purpose: present the active fraction in the same split layout for reads.
    always_comb begin
        frac_packed = '0;
        frac_packed[HI_PART-1:0]          = step_frac[FRAC_W-1:8];
        frac_packed[DATA_W-1:DATA_W-8]    = step_frac[7:0];
    end
endmodule

// File: rtl/ptp_frac_accum.sv
// Fraction accumulator: adds the fraction each cycle; overflow lengthens the step by 1 ns.
// Assumes: runs every cycle; a zero fraction leaves the accumulator unchanged.
module ptp_frac_accum
    import ptp_tod_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INC_NS_W-1:0] step_whole,
    input  logic [FRAC_W-1:0]   step_frac,
    output logic [STEP_W-1:0]   step_ns
);
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   acc_sum;

    // Purpose: form this cycle's sum and the effective nanosecond step.
    always_comb begin
        acc_sum = {1'b0, acc} + {1'b0, step_frac};
        step_ns = {1'b0, step_whole} + {{(STEP_W-1){1'b0}}, acc_sum[FRAC_W]};
    end

    // Purpose: keep the fractional remainder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else begin
            acc <= acc_sum[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/ptp_time_core.sv
// Time core: seconds/nanoseconds counters with rollover, loads and one-shot offset.
// Assumes: at most one register write per cycle; a bus write beats the counter.
module ptp_time_core
    import ptp_tod_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STEP_W-1:0]   step_ns,
    input  logic                ns_wr,
    input  logic                sec_hi_wr,
    input  logic                sec_lo_wr,
    input  logic                ofs_wr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [SEC_W-1:0]    sec,
    output logic [NS_W-1:0]     ns,
    output logic                pps
);
    localparam logic [NS_W:0] BILLION = (NS_W+1)'(NS_PER_SEC);

    logic [SEC_HI_W-1:0] sec_hi_stage;
    logic [NS_W:0]       run_sum;
    logic                run_wrap;
    logic [NS_W-1:0]     run_ns;
    logic [NS_W:0]       ofs_mag;
    logic                ofs_neg;
    logic                ofs_ok;
    logic                ofs_take;
    logic [NS_W:0]       add_sum;
    logic                add_carry;
    logic                sub_borrow;
    logic [NS_W:0]       sub_res;
    logic [NS_W-1:0]     ofs_ns;

    // Purpose: normal stepping result and its wrap at one second.
    always_comb begin
        run_sum  = {1'b0, ns} + (NS_W+1)'(step_ns);
        run_wrap = (run_sum >= BILLION);
        run_ns   = run_wrap ? NS_W'(run_sum - BILLION) : run_sum[NS_W-1:0];
    end

    // Purpose: signed offset result with borrow or carry into seconds.
    always_comb begin
        ofs_mag    = {1'b0, wr_data[NS_W-1:0]};
        ofs_neg    = wr_data[SIGN_BIT];
        ofs_ok     = (ofs_mag < BILLION);
        ofs_take   = ofs_wr && ofs_ok;
        add_sum    = {1'b0, ns} + ofs_mag;
        add_carry  = (add_sum >= BILLION);
        sub_borrow = (ofs_mag > {1'b0, ns});
        sub_res    = sub_borrow ? ({1'b0, ns} + BILLION - ofs_mag)
                                : ({1'b0, ns} - ofs_mag);
        if (ofs_neg) begin
            ofs_ns = sub_res[NS_W-1:0];
        end else begin
            ofs_ns = add_carry ? NS_W'(add_sum - BILLION) : add_sum[NS_W-1:0];
        end
    end

    // Purpose: update nanoseconds from bus write, offset, or step (in that priority).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ns <= '0;
        end else if (ns_wr) begin
            ns <= wr_data[NS_W-1:0];
        end else if (ofs_take) begin
            ns <= ofs_ns;
        end else begin
            ns <= run_ns;
        end
    end

    // Purpose: stage the seconds high half and load/advance the seconds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_hi_stage <= '0;
            sec          <= '0;
        end else begin
            if (sec_hi_wr) begin
                sec_hi_stage <= wr_data[SEC_HI_W-1:0];
            end
            if (sec_lo_wr) begin
                sec <= {sec_hi_stage, wr_data};
            end else if (ofs_take) begin
                if (ofs_neg && sub_borrow) begin
                    sec <= sec - 1'b1;
                end else if (!ofs_neg && add_carry) begin
                    sec <= sec + 1'b1;
                end
            end else if (!ns_wr && run_wrap) begin
                sec <= sec + 1'b1;
            end
        end
    end

    // Purpose: one-cycle pulse whenever seconds advance by a carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pps <= 1'b0;
        end else if (sec_lo_wr || ns_wr) begin
            pps <= 1'b0;
        end else if (ofs_take) begin
            pps <= !ofs_neg && add_carry;
        end else begin
            pps <= run_wrap;
        end
    end
endmodule

// File: rtl/ptp_tod_counter.sv
// Top: time-of-day counter with register write decode and read mux.
// Assumes: single write per cycle on wr_*; reads are combinational from rd_addr.
module ptp_tod_counter
    import ptp_tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [2:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic [47:0]       tod_sec,
    output logic [29:0]       tod_ns,
    output logic              pps_pulse
);
    logic [INC_NS_W-1:0] step_whole;
    logic [FRAC_W-1:0]   step_frac;
    logic [DATA_W-1:0]   frac_packed;
    logic [STEP_W-1:0]   step_ns;
    logic                wr_sec_hi, wr_sec_lo, wr_nsec, wr_whole, wr_frac, wr_ofs;

    // Purpose: decode the write offset into per-register strobes.
    always_comb begin
        wr_sec_hi = wr_en && (wr_addr == REG_SEC_HI);
        wr_sec_lo = wr_en && (wr_addr == REG_SEC_LO);
        wr_nsec   = wr_en && (wr_addr == REG_NSEC);
        wr_whole  = wr_en && (wr_addr == REG_STEP_NS);
        wr_frac   = wr_en && (wr_addr == REG_STEP_FR);
        wr_ofs    = wr_en && (wr_addr == REG_OFFSET);
    end

    ptp_step_regs u_step (
        .clk         (clk),
        .rst_n       (rst_n),
        .frac_wr     (wr_frac),
        .whole_wr    (wr_whole),
        .wr_data     (wr_data),
        .step_whole  (step_whole),
        .step_frac   (step_frac),
        .frac_packed (frac_packed)
    );

    ptp_frac_accum u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_whole (step_whole),
        .step_frac  (step_frac),
        .step_ns    (step_ns)
    );

    ptp_time_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_ns   (step_ns),
        .ns_wr     (wr_nsec),
        .sec_hi_wr (wr_sec_hi),
        .sec_lo_wr (wr_sec_lo),
        .ofs_wr    (wr_ofs),
        .wr_data   (wr_data),
        .sec       (tod_sec),
        .ns        (tod_ns),
        .pps       (pps_pulse)
    );

    // Purpose: return the selected register on the read port.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_SEC_HI:  rd_data[SEC_HI_W-1:0] = tod_sec[SEC_W-1:SEC_LO_W];
            REG_SEC_LO:  rd_data = tod_sec[SEC_LO_W-1:0];
            REG_NSEC:    rd_data[NS_W-1:0] = tod_ns;
            REG_STEP_NS: rd_data[INC_NS_W-1:0] = step_whole;
            REG_STEP_FR: rd_data = frac_packed;
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ptp_tod_counter_chk.sv
// Checker: temporal properties of the time-of-day counter at its ports.
module ptp_tod_counter_chk (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [47:0] tod_sec,
    input  logic [29:0] tod_ns,
    input  logic        pps_pulse
);
    // R5
    pulse_sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pps_pulse |-> (tod_sec == $past(tod_sec) + 48'd1));

    // R6
    sec_hi_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0) |=>
        ((tod_sec == $past(tod_sec)) || (tod_sec == $past(tod_sec) + 48'd1)));

    // R6
    sec_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd1) |=> (tod_sec[31:0] == $past(wr_data)));

    // R7
    ns_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd2) |=> ((tod_ns == $past(wr_data[29:0])) && !pps_pulse));

    // R10
    load_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd1) |=> !pps_pulse);
endmodule

bind ptp_tod_counter ptp_tod_counter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tod_sec   (tod_sec),
    .tod_ns    (tod_ns),
    .pps_pulse (pps_pulse)
);

// File: tb/tb_ptp_tod_counter.sv
// Directed bench for the time-of-day counter.
module tb_ptp_tod_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [47:0] tod_sec;
    logic [29:0] tod_ns;
    logic        pps_pulse;

    int checks = 0;
    int errors = 0;
    int pps_cnt = 0;

    ptp_tod_counter dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tod_sec(tod_sec), .tod_ns(tod_ns), .pps_pulse(pps_pulse)
    );

    always #10 clk = ~clk;

    always @(negedge clk) if (pps_pulse) pps_cnt++;

    task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge; leaves at the next negedge with reset released.
    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        pps_cnt = 0;
    endtask

    // One register write spanning exactly one rising edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        chk("R1 sec", tod_sec, 0);
        chk("R1 ns", tod_ns, 0);
        chk("R1 pps", pps_pulse, 0);
        rd(3'd3, d); chk("R1 step", d, 0);
        repeat (5) @(negedge clk);
        chk("R1 held", tod_ns, 0);
    endtask

    task automatic t_step();
        logic [31:0] d;
        logic [29:0] held;
        do_reset();
        wr(3'd4, 32'h0000_8000);
        repeat (3) @(negedge clk);
        chk("R4 staged only", tod_ns, 0);
        rd(3'd4, d); chk("R4 readback old", d, 0);
        wr(3'd3, 32'd10);
        chk("R2 commit edge", tod_ns, 0);
        repeat (4) @(negedge clk);
        chk("R2 fractional step", tod_ns, 42);
        rd(3'd4, d); chk("R3 packed", d, 32'h0000_8000);
        wr(3'd4, 32'hAB00_1234);
        wr(3'd3, 32'd10);
        rd(3'd4, d); chk("R3 split layout", d, 32'hAB00_1234);
        wr(3'd4, 32'h0);
        wr(3'd3, 32'h0);
        held = tod_ns;
        repeat (5) @(negedge clk);
        chk("R1 zero step stops", tod_ns, held);
    endtask

    task automatic t_rollover();
        do_reset();
        wr(3'd2, 32'd999_999_990);
        wr(3'd3, 32'd4);
        repeat (2) @(negedge clk);
        chk("R5 pre ns", tod_ns, 999_999_998);
        chk("R5 pre pps", pps_pulse, 0);
        @(negedge clk);
        chk("R5 wrap ns", tod_ns, 2);
        chk("R5 wrap sec", tod_sec, 1);
        chk("R5 pulse", pps_pulse, 1);
        @(negedge clk);
        chk("R5 pulse one cycle", pps_pulse, 0);
        chk("R5 after ns", tod_ns, 6);
    endtask

    task automatic t_seconds();
        logic [31:0] d;
        do_reset();
        wr(3'd0, 32'h0000_1234);
        chk("R6 hi staged", tod_sec, 0);
        wr(3'd1, 32'h89AB_CDEF);
        chk("R6 atomic load", tod_sec, 48'h1234_89AB_CDEF);
        rd(3'd0, d); chk("R6 read hi", d, 32'h1234);
        rd(3'd1, d); chk("R6 read lo", d, 32'h89AB_CDEF);
        rd(3'd2, d); chk("R6 read ns", d, 0);
        rd(3'd5, d); chk("R8 offset reads zero", d, 0);
    endtask

    task automatic t_ns_zero();
        do_reset();
        wr(3'd2, 32'd999_999_990);
        wr(3'd3, 32'd20);
        wr(3'd2, 32'd0);
        chk("R7 ns replaced", tod_ns, 0);
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd5);
        chk("R7 sec", tod_sec, 5);
        chk("R7 ns", tod_ns, 40);
        chk("R7 no carry", pps_cnt, 0);
    endtask

    task automatic t_offset();
        do_reset();
        wr(3'd1, 32'd10);
        wr(3'd2, 32'd100);
        wr(3'd5, 32'd50);
        chk("R8 add", tod_ns, 150);
        wr(3'd5, 32'h8000_001E);
        chk("R8 sub", tod_ns, 120);
        wr(3'd5, 32'h8000_012C);
        chk("R8 borrow ns", tod_ns, 999_999_820);
        chk("R8 borrow sec", tod_sec, 9);
        wr(3'd2, 32'd999_999_900);
        wr(3'd5, 32'd200);
        chk("R8 carry ns", tod_ns, 100);
        chk("R8 carry sec", tod_sec, 10);
        chk("R8 carry pulse", pps_pulse, 1);
        wr(3'd5, 32'h3B9A_CA00);
        chk("R9 big add ns", tod_ns, 100);
        chk("R9 big add sec", tod_sec, 10);
        wr(3'd5, 32'hBB9A_CA00);
        chk("R9 big sub ns", tod_ns, 100);
        chk("R9 big sub sec", tod_sec, 10);
    endtask

    task automatic t_collide();
        do_reset();
        wr(3'd2, 32'd999_999_994);
        wr(3'd3, 32'd4);
        wr(3'd0, 32'd0);
        chk("R10 pre ns", tod_ns, 999_999_998);
        wr(3'd1, 32'd77);
        chk("R10 sec wins", tod_sec, 77);
        chk("R10 ns wraps", tod_ns, 2);
        chk("R10 no pulse", pps_cnt, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_step();
        t_rollover();
        t_seconds();
        t_ns_zero();
        t_offset();
        t_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule